// File: doc/BRIEF.md
# Lane-to-Converter Sample Deassembler

This receive-side transport block takes lane-aligned octet words from a multi-lane converter link and rebuilds per-converter samples for a streaming sink. On every link-clock beat each lane delivers a 32-bit word, which is four octets. Each consecutive pair of octets is one 16-bit transmitted sample. Within that sample the converter data bits sit at the top and the control bits lie directly beneath them. The low-order padding bits that remain are cleared. The samples are then reordered from lane order into converter-major order. They cross from the link clock to the frame clock through a small dual-clock FIFO with Gray-coded pointers, and leave on a wide valid/ready bus.

Back-pressure works as follows:
- On the output side, a beat moves on any frame-clock edge where `smp_valid` and `smp_ready` are both high. While `smp_ready` is low, the presented beat holds unchanged.
- On the input side, a word is written on any link-clock edge where `link_valid` is high and the FIFO is not full. The block lowers `link_ready` early, when the FIFO is nearly full, so that a well-behaved source stops with margin to spare.
- A word presented while the FIFO is full is discarded. `link_err` then pulses for one link cycle.

The lane count, converter count, resolution and control-bit count are parameters. So are the octets per frame and the frame-clock divider. The octets per frame must be 1, 2, 4 or 8. A divider of 4 is legal only with one-octet frames. Illegal combinations are rejected when the design is elaborated.

Top module: `lane_sample_deasm`

## Requirements
- R1: After both resets are released, `smp_valid` is 0, `link_err` is 0 and `link_ready` is 1.
- R2: In every 16-bit output slot, the low 16-RESOLUTION-CTRL_BITS tail bits are 0, whatever the input holds. For example, all-ones input gives 16'hFFFE per slot when RESOLUTION=14 and CTRL_BITS=1.
- R3: In every output slot, bits [15:16-RESOLUTION] equal the top RESOLUTION bits of the source sample. The CTRL_BITS bits directly below them equal the next bits of the source sample.
- R4: Lane l carries its samples in bits [32l+31:32l]. Sample 2l is bits [32l+31:32l+16], so the most significant octet pair comes first. Sample 2l+1 is bits [32l+15:32l].
- R5: Sample s goes to converter c = s mod CONVERTERS, at time index t = s div CONVERTERS. It is placed in output slot j = c*(2*LANES/CONVERTERS)+t, which occupies `smp_data[16j+15:16j]`.
- R6: Every accepted input word appears exactly once on the output, in the order it was accepted.
- R7: While `smp_valid` is 1 and `smp_ready` is 0, the next frame cycle still has `smp_valid` at 1 and `smp_data` unchanged.
- R8: `link_ready` is 0 whenever the FIFO, as seen from the link side, holds 2^FIFO_AW-2 or more words. It is 1 when it holds fewer.
- R9: A word presented while the FIFO holds 2^FIFO_AW words is discarded. `link_err` is 1 for exactly the link cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| link_clk | input | 1 | Link-side clock |
| link_rst_n | input | 1 | Link-side reset, active low |
| link_valid | input | 1 | Input word present |
| link_data | input | LANES*32 | Lane words, lane 0 in the low 32 bits |
| link_ready | output | 1 | FIFO has room to spare |
| link_err | output | 1 | One-cycle pulse when a word is dropped on overflow |
| frame_clk | input | 1 | Frame-side clock |
| frame_rst_n | input | 1 | Frame-side reset, active low |
| smp_data | output | LANES*32 | Converter-major sample slots |
| smp_valid | output | 1 | Output beat present |
| smp_ready | input | 1 | Sink accepts the beat |

## Verification
The bench builds the block with two lanes, two converters, 14-bit resolution, one control bit and an eight-entry FIFO. With these values each converter gets two samples per beat, so the slot permutation mixes samples across lanes as well as within one. The single tail bit and the single control bit sit next to each other, which shows whether the mask boundary is off by one. The small FIFO lets a stalled sink drive the occupancy through the nearly-full threshold and into overflow within a few link cycles, while the two clocks run at unrelated periods.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  localparam int SMP_W = 16;
  localparam int LANE_W = 32;
  localparam int SMP_PER_LANE = LANE_W / SMP_W;

  function automatic logic [SMP_W-1:0] keep_mask(input int res, input int cbits);
    logic [SMP_W-1:0] m;
    for (int b = 0; b < SMP_W; b++) m[b] = (b >= SMP_W - res - cbits);
    return m;
  endfunction
endpackage

// File: rtl/lsd_sync2.sv
module lsd_sync2 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/lsd_tail_strip.sv
module lsd_tail_strip
  import lsd_pkg::*;
#(
  parameter int LANES      = 2,
  parameter int RESOLUTION = 14,
  parameter int CTRL_BITS  = 1
) (
  input  logic [LANES*LANE_W-1:0] raw,
  output logic [LANES*LANE_W-1:0] kept
);
  localparam int NSMP = LANES * SMP_PER_LANE;
  localparam logic [SMP_W-1:0] KEEP = keep_mask(RESOLUTION, CTRL_BITS);

  for (genvar s = 0; s < NSMP; s++) begin : g_smp
    assign kept[s*SMP_W +: SMP_W] = raw[s*SMP_W +: SMP_W] & KEEP;
  end
endmodule

// File: rtl/lsd_sample_map.sv
module lsd_sample_map
  import lsd_pkg::*;
#(
  parameter int LANES      = 2,
  parameter int CONVERTERS = 2
) (
  input  logic [LANES*LANE_W-1:0] lane_words,
  output logic [LANES*LANE_W-1:0] conv_words
);
  localparam int NSMP = LANES * SMP_PER_LANE;
  localparam int SPC  = NSMP / CONVERTERS;

  for (genvar j = 0; j < NSMP; j++) begin : g_slot
    localparam int C   = j / SPC;
    localparam int T   = j % SPC;
    localparam int S   = T * CONVERTERS + C;
    localparam int L   = S / SMP_PER_LANE;
    localparam int K   = S % SMP_PER_LANE;
    localparam int SRC = L * LANE_W + (SMP_PER_LANE - 1 - K) * SMP_W;
    assign conv_words[j*SMP_W +: SMP_W] = lane_words[SRC +: SMP_W];
  end
endmodule

// File: rtl/lsd_cdc_fifo.sv
module lsd_cdc_fifo #(
  parameter int W  = 64,
  parameter int AW = 3
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         wvalid,
  input  logic [W-1:0] wdata,
  output logic         wroom,
  output logic         werr,
  input  logic         rclk,
  input  logic         rrst_n,
  input  logic         rpop,
  output logic         rvalid,
  output logic [W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] DEPTH_P = DEPTH[AW:0];
  localparam logic [AW:0] NEAR_P  = DEPTH_P - 2;

  function automatic logic [AW:0] to_gray(input logic [AW:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [AW:0] from_gray(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0]  mem [DEPTH];
  logic [AW:0]   wbin, wgray, rbin, rgray;
  logic [AW:0]   rgray_w, wgray_r;
  logic [AW:0]   wcount;
  logic          wfull, rempty, wpush;

  lsd_sync2 #(.W(AW+1)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w));
  lsd_sync2 #(.W(AW+1)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r));

  assign wcount = wbin - from_gray(rgray_w);
  assign wfull  = (wcount == DEPTH_P);
  assign wroom  = (wcount < NEAR_P);
  assign wpush  = wvalid && !wfull;

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
      werr  <= 1'b0;
    end else begin
      werr <= wvalid && wfull;
      if (wpush) begin
        wbin  <= wbin + 1'b1;
        wgray <= to_gray(wbin + 1'b1);
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (wpush) mem[wbin[AW-1:0]] <= wdata;
  end

  assign rempty = (rgray == wgray_r);
  assign rvalid = !rempty;
  assign rdata  = mem[rbin[AW-1:0]];

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rpop && !rempty) begin
      rbin  <= rbin + 1'b1;
      rgray <= to_gray(rbin + 1'b1);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!wrst_n)
    wcount <= DEPTH_P) else $error("fifo occupancy beyond depth"); // R9
  AST_ROOM_BEFORE_FULL: assert property (@(posedge wclk) disable iff (!wrst_n)
    wfull |-> !wroom) else $error("ready high while full"); // R8
  AST_DROP_FLAGGED: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wvalid && wfull) |=> (werr && $stable(wbin))) else $error("overflow not flagged"); // R9
endmodule

// File: rtl/lane_sample_deasm.sv
module lane_sample_deasm
  import lsd_pkg::*;
#(
  parameter int LANES            = 2,
  parameter int OCTETS_PER_FRAME = 2,
  parameter int CONVERTERS       = 2,
  parameter int RESOLUTION       = 14,
  parameter int CTRL_BITS        = 1,
  parameter int FRAME_DIV        = 1,
  parameter int FIFO_AW          = 3,
  localparam int W = LANES * LANE_W
) (
  input  logic         link_clk,
  input  logic         link_rst_n,
  input  logic         link_valid,
  input  logic [W-1:0] link_data,
  output logic         link_ready,
  output logic         link_err,
  input  logic         frame_clk,
  input  logic         frame_rst_n,
  output logic [W-1:0] smp_data,
  output logic         smp_valid,
  input  logic         smp_ready
);
  localparam int NSMP = LANES * SMP_PER_LANE;
  localparam logic [SMP_W-1:0] KEEP = keep_mask(RESOLUTION, CTRL_BITS);

  if (!(OCTETS_PER_FRAME == 1 || OCTETS_PER_FRAME == 2 ||
        OCTETS_PER_FRAME == 4 || OCTETS_PER_FRAME == 8)) begin : g_bad_opf
    $error("octets per frame must be 1, 2, 4 or 8");
  end
  if (!(FRAME_DIV == 1 || (FRAME_DIV == 4 && OCTETS_PER_FRAME == 1))) begin : g_bad_div
    $error("frame divider 4 needs one-octet frames");
  end
  if (NSMP % CONVERTERS != 0 || RESOLUTION < 12 || RESOLUTION > 16 ||
      CTRL_BITS < 0 || CTRL_BITS > 3 || RESOLUTION + CTRL_BITS > SMP_W) begin : g_bad_fmt
    $error("illegal sample format or converter count");
  end
  if (FIFO_AW < 2) begin : g_bad_fifo
    $error("fifo needs at least four entries");
  end

  logic [W-1:0] stripped, mapped, fifo_q;
  logic         fifo_nonempty, fifo_pop;

  lsd_tail_strip #(.LANES(LANES), .RESOLUTION(RESOLUTION), .CTRL_BITS(CTRL_BITS)) u_strip (
    .raw (link_data),
    .kept(stripped)
  );

  lsd_sample_map #(.LANES(LANES), .CONVERTERS(CONVERTERS)) u_map (
    .lane_words(stripped),
    .conv_words(mapped)
  );

  lsd_cdc_fifo #(.W(W), .AW(FIFO_AW)) u_fifo (
    .wclk  (link_clk),
    .wrst_n(link_rst_n),
    .wvalid(link_valid),
    .wdata (mapped),
    .wroom (link_ready),
    .werr  (link_err),
    .rclk  (frame_clk),
    .rrst_n(frame_rst_n),
    .rpop  (fifo_pop),
    .rvalid(fifo_nonempty),
    .rdata (fifo_q)
  );

  assign fifo_pop = fifo_nonempty && (!smp_valid || smp_ready);

  always_ff @(posedge frame_clk or negedge frame_rst_n) begin
    if (!frame_rst_n) begin
      smp_valid <= 1'b0;
      smp_data  <= '0;
    end else if (!smp_valid || smp_ready) begin
      smp_valid <= fifo_nonempty;
      if (fifo_nonempty) smp_data <= fifo_q;
    end
  end

  logic [W-1:0] tail_bus;
  always_comb begin
    for (int s = 0; s < NSMP; s++) tail_bus[s*SMP_W +: SMP_W] = ~KEEP;
  end

  AST_HOLD_STALL: assert property (@(posedge frame_clk) disable iff (!frame_rst_n)
    (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data))) else $error("beat changed under stall"); // R7
  AST_TAIL_CLEAR: assert property (@(posedge frame_clk) disable iff (!frame_rst_n)
    smp_valid |-> ((smp_data & tail_bus) == '0)) else $error("tail bits leaked"); // R2
  AST_VALID_FROM_FIFO: assert property (@(posedge frame_clk) disable iff (!frame_rst_n)
    $rose(smp_valid) |-> $past(fifo_nonempty)) else $error("beat without fifo data"); // R6
endmodule

// File: tb/lane_sample_deasm_tb.sv
module lane_sample_deasm_tb;
  localparam int LP = 10;
  localparam int FP = 14;
  localparam int LANES = 2, CONV = 2, RES = 14, CB = 1, AW = 3;
  localparam int W = LANES * 32;
  localparam int DEPTH = 1 << AW;
  localparam int NSMP = LANES * 2;
  localparam int SPC = NSMP / CONV;

  logic link_clk = 0, frame_clk = 0;
  logic link_rst_n = 0, frame_rst_n = 0;
  logic link_valid = 0, smp_ready = 0;
  logic [W-1:0] link_data = '0;
  logic link_ready, link_err, smp_valid;
  logic [W-1:0] smp_data;

  always #(LP/2) link_clk = ~link_clk;
  always #(FP/2) frame_clk = ~frame_clk;

  lane_sample_deasm #(.LANES(LANES), .OCTETS_PER_FRAME(2), .CONVERTERS(CONV),
    .RESOLUTION(RES), .CTRL_BITS(CB), .FRAME_DIV(1), .FIFO_AW(AW)) u_dut (
    .link_clk(link_clk), .link_rst_n(link_rst_n), .link_valid(link_valid),
    .link_data(link_data), .link_ready(link_ready), .link_err(link_err),
    .frame_clk(frame_clk), .frame_rst_n(frame_rst_n), .smp_data(smp_data),
    .smp_valid(smp_valid), .smp_ready(smp_ready));

  int checks = 0, fails = 0, received = 0, accepted = 0;
  logic [W-1:0] expq[$];
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R2 R3 R4 R5: expected beat from the requirement text
  function automatic logic [W-1:0] model(input logic [W-1:0] w);
    logic [W-1:0] o;
    logic [15:0] keep;
    keep = 16'hFFFF << (16 - RES - CB);
    for (int j = 0; j < NSMP; j++) begin
      int c, t, s, l, k;
      c = j / SPC; t = j % SPC; s = t * CONV + c; l = s / 2; k = s % 2;
      o[j*16 +: 16] = w[l*32 + (1-k)*16 +: 16] & keep;
    end
    return o;
  endfunction

  task automatic push(input logic [W-1:0] w, input bit expect_take);
    @(negedge link_clk);
    link_valid = 1; link_data = w;
    if (expect_take) begin expq.push_back(model(w)); accepted++; end
    @(negedge link_clk);
    link_valid = 0;
  endtask

  task automatic push_polite(input logic [W-1:0] w);
    while (!link_ready) @(negedge link_clk);
    push(w, 1);
  endtask

  initial begin : monitor
    logic [W-1:0] e;
    forever begin
      @(negedge frame_clk); #1;
      if (smp_valid && smp_ready) begin
        received++;
        if (expq.size() == 0) chk(0, "R6 unexpected beat", smp_data, '0);
        else begin
          e = expq.pop_front();
          chk(smp_data == e, "R5 beat content", smp_data, e);
        end
      end
    end
  end

  initial begin : watchdog
    #(LP * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R6 watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] held;
    repeat (4) @(negedge link_clk);
    link_rst_n = 1; frame_rst_n = 1;
    repeat (3) @(negedge link_clk);
    chk(smp_valid == 0, "R1 valid after reset", W'(smp_valid), 0);
    chk(link_err == 0, "R1 err after reset", W'(link_err), 0);
    chk(link_ready == 1, "R1 ready after reset", W'(link_ready), 1);

    // R4 R5 ordering with distinct samples; R2 R3 with all-ones and patterns
    @(negedge frame_clk); smp_ready = 1;
    push_polite(64'h1111_2222_3333_4444);
    push_polite({64{1'b1}});
    push_polite(64'hA5A5_5A5A_0F0F_F0F0);
    push_polite(64'h0001_0002_0003_0004);
    for (int i = 0; i < 16; i++) push_polite({$urandom(), $urandom()});
    repeat (40) @(negedge link_clk);
    chk(expq.size() == 0, "R6 drain after burst", W'(expq.size()), 0);
    chk(model({64{1'b1}}) == {4{16'hFFFE}}, "R2 tail mask model", model({64{1'b1}}), {4{16'hFFFE}});

    // stall: one word into output register, then fill the fifo
    @(negedge frame_clk); smp_ready = 0;
    push(64'hDEAD_BEEF_0123_4567, 1);
    repeat (20) @(negedge link_clk);
    @(negedge frame_clk); #1;
    held = smp_data;
    chk(smp_valid == 1, "R7 valid under stall", W'(smp_valid), 1);
    for (int i = 0; i < DEPTH - 3; i++) push(64'h1000_0000_0000_0000 + 64'(i), 1);
    chk(link_ready == 1, "R8 ready below threshold", W'(link_ready), 1);
    push(64'h2000_0000_0000_0001, 1);
    chk(link_ready == 0, "R8 ready at threshold", W'(link_ready), 0);
    push(64'h3000_0000_0000_0002, 1);
    push(64'h3000_0000_0000_0003, 1);
    chk(link_err == 0, "R9 no error before full", W'(link_err), 0);
    push(64'h4444_4444_4444_4444, 0);
    chk(link_err == 1, "R9 error pulse on drop", W'(link_err), 1);
    @(negedge link_clk);
    chk(link_err == 0, "R9 error lasts one cycle", W'(link_err), 0);
    @(negedge frame_clk); #1;
    chk(smp_valid == 1 && smp_data == held, "R7 beat held", smp_data, held);

    // release and drain
    @(negedge frame_clk); smp_ready = 1;
    repeat (60) @(negedge link_clk);
    chk(expq.size() == 0, "R6 drain after stall", W'(expq.size()), 0);

    // toggling sink with streaming source
    fork
      begin
        for (int i = 0; i < 40; i++) begin
          @(negedge frame_clk); smp_ready = (i % 3) != 0;
        end
        @(negedge frame_clk); smp_ready = 1;
      end
      for (int i = 0; i < 30; i++) push_polite({$urandom(), $urandom()});
    join
    repeat (60) @(negedge link_clk);
    chk(expq.size() == 0, "R6 drain after toggling", W'(expq.size()), 0);
    chk(received == accepted, "R6 beat count", W'(received), W'(accepted));
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule